// File: doc/BRIEF.md
# Register Scoreboard with Operand Bypass

This block is the operand hazard unit that sits between decode and execute in an in-order pipeline whose execute, three memory stages and writeback can each hold a result. It owns the architectural register file and a busy tag for every register. The tag is the sequence number of the youngest instruction still in flight that will write that register, and zero marks the register as settled. For the instruction waiting in decode, the block resolves each of its two source operands. A source is read from the register file when its tag is clear. Otherwise it is taken from a later stage's result, or it is declared not ready, and a not-ready operand raises a stall.

Every cycle the later stages present a valid bit, a destination register, a result value, a load flag and a "produced this cycle" flag. The block scans them from execute toward writeback and takes the first eligible match. A match that was produced in the current cycle does not supply a value; it stalls decode. An operand that resolves while its partner is still pending is captured, so a stalled instruction does not lose it when the producing stage moves on. Load and store instructions receive their base operand as a word index, which is the byte address shifted right by three.

Top module: `tag_scoreboard`

## Requirements
- R1: After reset every tag and every register value is zero, and `stall` is low whenever `id_valid` is low.
- R2: A source register whose tag is zero is supplied from the register file.
- R3: When an add (`id_op`=0), subtract (1) or load (2) leaves decode (`id_valid` high, `stall` low), the tag of `id_rd` becomes `id_seq`. A store (3) or branch (4) leaves every tag unchanged.
- R4: A writeback updates the register value and clears its tag only when `wb_seq` equals the stored tag. A writeback carrying any other sequence number changes neither the tag nor the value.
- R5: For a busy source, the stages are scanned in order execute (slot 0), M1 (1), M2 (2), M3 (3), writeback (4). Slot k occupies bits [k*5 +: 5] of `stg_rd` and [k*32 +: 32] of `stg_val`. The first valid slot whose destination equals the source supplies the operand.
- R6: If that first match has its `stg_fresh` bit set, decode stalls even when a later slot holds a usable copy.
- R7: A busy source with no eligible match stalls decode.
- R8: A slot with `stg_ld` set is not eligible in slots 0 and 1. The scan skips it and continues, and from slot 2 onward it is eligible.
- R9: For a load or store, operand A is the resolved value shifted right by 3, whether it comes from the register file or from a bypass. Operand B is never shifted.
- R10: An operand resolved during a stall is held with its value until the instruction leaves decode. Held operands are then dropped, so the next instruction resolves its own.
- R11: A source whose use bit is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_op | input | 3 | Operation: 0 add, 1 subtract, 2 load, 3 store, 4 branch |
| id_seq | input | 8 | Nonzero sequence number of the decode instruction |
| id_rd | input | 5 | Destination register |
| id_use_a | input | 1 | Operand A reads a register |
| id_src_a | input | 5 | Operand A register (base for load/store) |
| id_use_b | input | 1 | Operand B reads a register |
| id_src_b | input | 5 | Operand B register (store data, branch test) |
| stg_vld | input | 5 | Per-slot result valid |
| stg_ld | input | 5 | Per-slot result comes from a load |
| stg_fresh | input | 5 | Per-slot result was produced this cycle |
| stg_rd | input | 25 | Per-slot destination register |
| stg_val | input | 160 | Per-slot result value |
| wb_en | input | 1 | Writeback request |
| wb_rd | input | 5 | Writeback register |
| wb_seq | input | 8 | Sequence number of the retiring instruction |
| wb_val | input | 32 | Writeback value |
| stall | output | 1 | Decode must hold this cycle |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
A tag that is wrong on the busy side shows up as a stall on the next read of that register when no stage offers a copy. A tag that is wrong on the clear side lets a stale register value through `opnd_a` or `opnd_b` in the same cycle the reader appears. Scan order and load eligibility faults appear as the wrong stage's value in the cycle the match is presented. A held operand that is lost or kept too long becomes visible one cycle after the producing stage leaves, or on the first operand of the next instruction. The scenarios therefore place each read immediately after the state change it depends on, so a fault shows up within one or two cycles.

// File: rtl/tag_scoreboard.sv
`timescale 1ns/1ps
module tag_scoreboard #(
  parameter int NREG     = 32,
  parameter int XLEN     = 32,
  parameter int SEQW     = 8,
  parameter int NSTG     = 5,
  parameter int LD_FIRST = 2,
  parameter int SHIFT    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   id_valid,
  input  logic [2:0]             id_op,
  input  logic [SEQW-1:0]        id_seq,
  input  logic [$clog2(NREG)-1:0] id_rd,
  input  logic                   id_use_a,
  input  logic [$clog2(NREG)-1:0] id_src_a,
  input  logic                   id_use_b,
  input  logic [$clog2(NREG)-1:0] id_src_b,
  input  logic [NSTG-1:0]        stg_vld,
  input  logic [NSTG-1:0]        stg_ld,
  input  logic [NSTG-1:0]        stg_fresh,
  input  logic [NSTG*$clog2(NREG)-1:0] stg_rd,
  input  logic [NSTG*XLEN-1:0]   stg_val,
  input  logic                   wb_en,
  input  logic [$clog2(NREG)-1:0] wb_rd,
  input  logic [SEQW-1:0]        wb_seq,
  input  logic [XLEN-1:0]        wb_val,
  output logic                   stall,
  output logic [XLEN-1:0]        opnd_a,
  output logic [XLEN-1:0]        opnd_b
);
  localparam int RW = $clog2(NREG);
  localparam logic [2:0] OP_LOAD  = 3'd2;
  localparam logic [2:0] OP_STORE = 3'd3;

  logic [SEQW-1:0] tag_q [NREG];
  logic [XLEN-1:0] rf_q  [NREG];

  logic          writer, is_mem, adv;
  logic [RW-1:0] src_sel [2];
  logic          use_sel [2];

  assign writer = id_op <= OP_LOAD;
  assign is_mem = (id_op == OP_LOAD) || (id_op == OP_STORE);
  assign src_sel[0] = id_src_a;
  assign src_sel[1] = id_src_b;
  assign use_sel[0] = id_use_a;
  assign use_sel[1] = id_use_b;

  for (genvar g = 0; g < 2; g++) begin : gen_src
    logic            hit, hfresh, idle, live_ok, held, ok;
    logic [XLEN-1:0] hval, raw, live_val, held_val, val;

    always_comb begin
      hit = 1'b0;
      hfresh = 1'b0;
      hval = '0;
      for (int k = 0; k < NSTG; k++) begin
        if (!hit && stg_vld[k] && stg_rd[k*RW +: RW] == src_sel[g]
            && !(stg_ld[k] && k < LD_FIRST)) begin
          hit = 1'b1;
          hfresh = stg_fresh[k];
          hval = stg_val[k*XLEN +: XLEN];
        end
      end
    end

    assign idle    = tag_q[src_sel[g]] == '0;
    assign live_ok = idle || (hit && !hfresh);
    assign raw     = idle ? rf_q[src_sel[g]] : hval;

    if (g == 0) begin : g_base
      assign live_val = is_mem ? raw >> SHIFT : raw;
    end else begin : g_plain
      assign live_val = raw;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !id_valid || adv) begin
        held     <= 1'b0;
        held_val <= '0;
      end else if (!held && use_sel[g] && live_ok) begin
        held     <= 1'b1;
        held_val <= live_val;
      end
    end

    assign ok  = !use_sel[g] || held || live_ok;
    assign val = held ? held_val : live_val;
  end

  assign stall  = id_valid && !(gen_src[0].ok && gen_src[1].ok);
  assign adv    = id_valid && !stall;
  assign opnd_a = gen_src[0].val;
  assign opnd_b = gen_src[1].val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        tag_q[i] <= '0;
        rf_q[i]  <= '0;
      end
    end else begin
      if (wb_en && tag_q[wb_rd] == wb_seq) begin
        tag_q[wb_rd] <= '0;
        rf_q[wb_rd]  <= wb_val;
      end
      if (adv && writer) tag_q[id_rd] <= id_seq;
    end
  end
endmodule

module tag_scoreboard_chk #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int SEQW = 8,
  parameter int NSTG = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    id_valid,
  input logic [2:0]              id_op,
  input logic [SEQW-1:0]         id_seq,
  input logic [$clog2(NREG)-1:0] id_rd,
  input logic                    id_use_a,
  input logic [$clog2(NREG)-1:0] id_src_a,
  input logic [NSTG-1:0]         stg_vld,
  input logic [NSTG-1:0]         stg_ld,
  input logic [NSTG-1:0]         stg_fresh,
  input logic [NSTG*$clog2(NREG)-1:0] stg_rd,
  input logic                    wb_en,
  input logic [$clog2(NREG)-1:0] wb_rd,
  input logic [SEQW-1:0]         wb_seq,
  input logic                    stall,
  input logic                    adv,
  input logic                    held_a,
  input logic                    held_b,
  input logic [XLEN-1:0]         held_val_a,
  input logic [SEQW-1:0]         tag_q [NREG]
);
  localparam int RW = $clog2(NREG);

  p_idle_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall);

  p_tag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && id_op <= 3'd2 |=> tag_q[$past(id_rd)] == $past(id_seq));

  p_wb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && wb_seq != '0 && tag_q[wb_rd] == wb_seq
    && !(adv && id_op <= 3'd2 && id_rd == wb_rd)
    |=> tag_q[$past(wb_rd)] == '0);

  p_fresh_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && id_use_a && !held_a && tag_q[id_src_a] != '0 && stg_vld[0]
    && stg_rd[RW-1:0] == id_src_a && !stg_ld[0] && stg_fresh[0] |-> stall);

  p_hold_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held_a |=> !held_a || $stable(held_val_a));

  p_drop_on_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !held_a && !held_b);
endmodule

bind tag_scoreboard tag_scoreboard_chk #(
  .NREG(NREG), .XLEN(XLEN), .SEQW(SEQW), .NSTG(NSTG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
  .id_seq(id_seq), .id_rd(id_rd), .id_use_a(id_use_a), .id_src_a(id_src_a),
  .stg_vld(stg_vld), .stg_ld(stg_ld), .stg_fresh(stg_fresh), .stg_rd(stg_rd),
  .wb_en(wb_en), .wb_rd(wb_rd), .wb_seq(wb_seq), .stall(stall), .adv(adv),
  .held_a(gen_src[0].held), .held_b(gen_src[1].held),
  .held_val_a(gen_src[0].held_val), .tag_q(tag_q)
);

// File: tb/tag_scoreboard_bench.sv
`timescale 1ns/1ps
module tag_scoreboard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid, id_use_a, id_use_b, wb_en;
  logic [2:0] id_op;
  logic [7:0] id_seq, wb_seq;
  logic [4:0] id_rd, id_src_a, id_src_b, wb_rd;
  logic [4:0] stg_vld, stg_ld, stg_fresh;
  logic [24:0] stg_rd;
  logic [159:0] stg_val;
  logic [31:0] wb_val, opnd_a, opnd_b;
  logic stall;

  typedef struct {
    logic st; logic [31:0] a; logic [31:0] b; bit ca; bit cb; string req;
  } item_t;
  item_t q[$];
  item_t it;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tag_scoreboard u_tag_scoreboard (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
    .id_seq(id_seq), .id_rd(id_rd), .id_use_a(id_use_a), .id_src_a(id_src_a),
    .id_use_b(id_use_b), .id_src_b(id_src_b), .stg_vld(stg_vld),
    .stg_ld(stg_ld), .stg_fresh(stg_fresh), .stg_rd(stg_rd),
    .stg_val(stg_val), .wb_en(wb_en), .wb_rd(wb_rd), .wb_seq(wb_seq),
    .wb_val(wb_val), .stall(stall), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  always @(negedge clk) begin
    while (q.size() != 0) begin
      it = q.pop_front();
      checks++;
      if (stall !== it.st) begin
        fails++;
        $display("FAIL %s stall actual %0b expected %0b", it.req, stall, it.st);
      end
      if (it.ca) begin
        checks++;
        if (opnd_a !== it.a) begin
          fails++;
          $display("FAIL %s opnd_a actual %0d expected %0d", it.req, opnd_a, it.a);
        end
      end
      if (it.cb) begin
        checks++;
        if (opnd_b !== it.b) begin
          fails++;
          $display("FAIL %s opnd_b actual %0d expected %0d", it.req, opnd_b, it.b);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    id_valid = 0; id_op = 0; id_seq = 0; id_rd = 0;
    id_use_a = 0; id_src_a = 0; id_use_b = 0; id_src_b = 0;
    stg_vld = 0; stg_ld = 0; stg_fresh = 0; stg_rd = 0; stg_val = 0;
    wb_en = 0; wb_rd = 0; wb_seq = 0; wb_val = 0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] seq, input logic [4:0] rd,
                       input logic ua, input logic [4:0] a, input logic ub, input logic [4:0] b);
    id_valid = 1; id_op = op; id_seq = seq; id_rd = rd;
    id_use_a = ua; id_src_a = a; id_use_b = ub; id_src_b = b;
  endtask

  task automatic put(input int k, input logic [4:0] rd, input logic [31:0] v,
                     input logic ld, input logic fr);
    stg_vld[k] = 1; stg_rd[k*5 +: 5] = rd; stg_val[k*32 +: 32] = v;
    stg_ld[k] = ld; stg_fresh[k] = fr;
  endtask

  task automatic wb(input logic [4:0] rd, input logic [7:0] seq, input logic [31:0] v);
    wb_en = 1; wb_rd = rd; wb_seq = seq; wb_val = v;
  endtask

  task automatic expect_it(input logic st, input logic [31:0] a, input logic [31:0] b,
                           input bit ca, input bit cb, input string req);
    item_t n;
    n.st = st; n.a = a; n.b = b; n.ca = ca; n.cb = cb; n.req = req;
    q.push_back(n);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: cleared state, store reads zeros
    tick(); issue(3, 20, 31, 1, 5, 1, 6); expect_it(0, 0, 0, 1, 1, "R1");
    tick(); expect_it(0, 0, 0, 0, 0, "R1");
    // R11 / R3: add with no sources issues and marks r3
    tick(); issue(0, 1, 3, 0, 0, 0, 0); expect_it(0, 0, 0, 0, 0, "R11");
    tick(); issue(0, 2, 4, 1, 3, 0, 0); expect_it(1, 0, 0, 0, 0, "R7");
    tick(); issue(0, 2, 4, 1, 3, 0, 0); put(0, 3, 100, 0, 1); expect_it(1, 0, 0, 0, 0, "R6");
    tick(); issue(0, 2, 4, 1, 3, 0, 0); put(0, 3, 100, 0, 1); put(1, 3, 33, 0, 0);
    expect_it(1, 0, 0, 0, 0, "R6");
    tick(); issue(0, 2, 4, 1, 3, 0, 0); put(0, 3, 100, 0, 0); expect_it(0, 100, 0, 1, 1, "R5");
    tick(); issue(0, 3, 7, 1, 3, 0, 0); put(0, 3, 11, 0, 0); put(2, 3, 22, 0, 0);
    expect_it(0, 11, 0, 1, 0, "R5");
    // R8: load results skipped in early slots
    tick(); issue(0, 4, 8, 1, 3, 0, 0); put(0, 3, 44, 1, 0); put(1, 3, 55, 1, 0);
    expect_it(1, 0, 0, 0, 0, "R8");
    tick(); issue(0, 4, 8, 1, 3, 0, 0); put(0, 3, 44, 1, 0); put(1, 3, 55, 1, 0);
    put(2, 3, 66, 1, 0); expect_it(0, 66, 0, 1, 0, "R8");
    // R4 / R2: matching writeback releases r3
    tick(); wb(3, 1, 500); expect_it(0, 0, 0, 0, 0, "R4");
    tick(); issue(4, 5, 10, 0, 0, 1, 3); expect_it(0, 0, 500, 1, 1, "R2");
    tick(); issue(4, 5, 10, 0, 0, 1, 10); expect_it(0, 0, 0, 0, 1, "R3");
    tick(); issue(4, 5, 10, 0, 0, 1, 31); expect_it(0, 0, 0, 0, 1, "R3");
    tick(); wb(4, 9, 777); expect_it(0, 0, 0, 0, 0, "R4");
    tick(); issue(4, 5, 10, 0, 0, 1, 4); expect_it(1, 0, 0, 0, 0, "R4");
    tick(); wb(4, 2, 888); expect_it(0, 0, 0, 0, 0, "R4");
    tick(); issue(4, 5, 10, 0, 0, 1, 4); expect_it(0, 0, 888, 0, 1, "R4");
    tick(); wb(4, 9, 777); expect_it(0, 0, 0, 0, 0, "R4");
    tick(); issue(4, 5, 10, 0, 0, 1, 4); expect_it(0, 0, 888, 0, 1, "R4");
    // R9: base shifted to word index
    tick(); issue(2, 6, 12, 1, 3, 0, 0); expect_it(0, 62, 0, 1, 0, "R9");
    tick(); issue(0, 7, 9, 0, 0, 0, 0); expect_it(0, 0, 0, 0, 0, "R11");
    tick(); issue(3, 30, 0, 1, 9, 1, 9); put(4, 9, 800, 0, 0);
    expect_it(0, 100, 800, 1, 1, "R9");
    // R10: capture, hold, drop
    tick(); issue(0, 8, 14, 1, 9, 1, 12); put(4, 9, 800, 0, 0);
    expect_it(1, 800, 0, 1, 0, "R10");
    tick(); issue(0, 8, 14, 1, 9, 1, 12); expect_it(1, 800, 0, 1, 0, "R10");
    tick(); issue(0, 8, 14, 1, 9, 1, 12); put(3, 12, 40, 0, 0);
    expect_it(0, 800, 40, 1, 1, "R10");
    tick(); issue(0, 9, 15, 1, 9, 0, 0); expect_it(1, 0, 0, 0, 0, "R10");
    tick(); issue(0, 10, 16, 0, 9, 0, 12); expect_it(0, 0, 0, 0, 0, "R11");
    tick(); expect_it(0, 0, 0, 0, 0, "R1");
    tick();
    @(negedge clk); #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule